// File: doc/BRIEF.md
# Lost Interrupt Reinjection Tracker

This block sits beside a periodic interrupt source and keeps a count of the periodic interrupts that the interrupt controller reports as not taken. It then replays them later, so that software which counts ticks does not fall behind. A replay is attempted in one of two ways. The first is straight after the host acknowledges by reading its status register, with a limit on how many acknowledgements in a row can be turned into replays. The second is a catch-up timer that cuts the current period into two to eight slices, using more slices as the backlog grows.

Each assertion attempt shows as a one-cycle pulse on `irq_req_o`. The interrupt path answers with `dlv_ok_i` during that same pulse cycle. An undelivered periodic attempt adds one to the backlog, and a delivered replay or catch-up attempt takes one away. When the period setting changes, the backlog is rescaled so that it still stands for the same span of lost time. Period generation and the status register itself live outside this block. `clr_sts_o` tells the register file when an acknowledgement is allowed to clear the status.

Top module: `lost_irq_replay`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `backlog_o` = 0, `irq_req_o` = 0 and `clr_sts_o` = 0.
- R2: A `tick_i` strobe sampled at an edge makes `irq_req_o` high for the following cycle. If `dlv_ok_i` is low in that cycle, `backlog_o` goes up by one at the next edge.
- R3: `backlog_o` saturates at 2^BL_W-1 (255 by default). A decrement never takes it below 0.
- R4: When `period_i` differs from the registered period at an edge and is nonzero, the backlog first becomes floor(backlog × old / new), saturated, and then that edge's delivery adjustment is applied. A new period of 0 leaves the backlog unchanged.
- R5: An `ack_rd_i` without `tick_i`, with a nonzero backlog and a replay count below ACK_CAP (20), starts a replay attempt. `irq_req_o` goes high next cycle, `clr_sts_o` stays low, and the replay count goes up by one. If `dlv_ok_i` is high in the attempt cycle, the backlog goes down by one.
- R6: An `ack_rd_i` that does not start a replay gives a one-cycle `clr_sts_o` pulse in the next cycle. This covers a zero backlog, a replay count already at ACK_CAP, and a `tick_i` in the same cycle.
- R7: A `tick_i` while the replay count equals ACK_CAP resets the count to 0, so the next qualifying `ack_rd_i` replays again.
- R8: While the backlog is nonzero, a catch-up attempt is due once a slice counter reaches S = max(1, period / (min(backlog, 7) + 1)). The counter restarts after each firing. A delivered catch-up attempt decrements the backlog.
- R9: With a zero backlog, no catch-up attempt is made and the slice counter is held at zero.
- R10: Only one attempt starts per edge, in priority order tick, then acknowledge replay, then catch-up. A catch-up attempt also waits while any attempt is in its feedback cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Periodic interrupt event strobe |
| ack_rd_i | input | 1 | Status-register read strobe (acknowledge) |
| dlv_ok_i | input | 1 | Delivery feedback, valid in the cycle `irq_req_o` is high |
| period_i | input | PER_W | Current period in base clock cycles |
| irq_req_o | output | 1 | One-cycle interrupt assertion attempt |
| clr_sts_o | output | 1 | One-cycle permission to clear the status register |
| backlog_o | output | BL_W | Count of undelivered interrupts still owed |

## Verification
Every strobe sampled at edge N produces its `irq_req_o` or `clr_sts_o` pulse in the cycle after N. The backlog effect of that attempt appears only after edge N+1, because the feedback is taken in the pulse cycle. A period change or a catch-up firing is counted from the registered period and backlog at the edge where it happens. The bench drives inputs on the falling edge and advances a reference model at each rising edge. It compares all three outputs at the following falling edge, so every output is checked in the exact cycle it is due. Directed sequences pin down the cap of 20, the tick reset of that cap, the rescale arithmetic, saturation and the full drain to zero.

// File: rtl/lirq_pkg.sv
// Shared types for the lost interrupt reinjection tracker.
package lirq_pkg;
    // Kind of assertion attempt currently waiting for delivery feedback.
    typedef enum logic [1:0] {
        ATT_NONE   = 2'd0,
        ATT_TICK   = 2'd1,
        ATT_REPLAY = 2'd2,
        ATT_CATCH  = 2'd3
    } att_kind_e;
endpackage

// File: rtl/lirq_rescale.sv
// Backlog rescaler: converts a backlog counted in old periods into new periods.
// Assumes: purely combinational; new period 0 or unchanged period passes through.
module lirq_rescale #(
    parameter int BL_W  = 8,
    parameter int PER_W = 12
) (
    input  logic [BL_W-1:0]  bl_i,
    input  logic [PER_W-1:0] old_per_i,
    input  logic [PER_W-1:0] new_per_i,
    output logic [BL_W-1:0]  bl_o
);
    localparam int PROD_W = BL_W + PER_W;
    localparam logic [BL_W-1:0] BL_MAX = '1;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;

    // Scale product and quotient; divisor guarded against zero.
    always_comb begin
        prod = PROD_W'(bl_i) * PROD_W'(old_per_i);
        quo  = (new_per_i == '0) ? '0 : prod / PROD_W'(new_per_i);
    end

    // Select pass-through, saturated or scaled result.
    always_comb begin
        if (new_per_i == '0 || new_per_i == old_per_i) begin
            bl_o = bl_i;
        end else if (quo > PROD_W'(BL_MAX)) begin
            bl_o = BL_MAX;
        end else begin
            bl_o = quo[BL_W-1:0];
        end
    end
endmodule

// File: rtl/lirq_ack_gate.sv
// Acknowledge replay gate: decides whether a status read becomes a replay,
// and counts consecutive replays up to CAP.
// Assumes: a tick in the same cycle takes precedence over the replay.
module lirq_ack_gate #(
    parameter int CAP = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ack_i,
    input  logic bl_nz_i,
    output logic replay_o
);
    localparam int RC_W = $clog2(CAP + 1);
    localparam logic [RC_W-1:0] RC_CAP = RC_W'(CAP);

    logic [RC_W-1:0] rep_q;

    // Replay when acknowledged, backlog owed and cap not yet reached.
    assign replay_o = ack_i && !tick_i && bl_nz_i && (rep_q < RC_CAP);

    // Replay counter: reset on a tick at the cap, count each replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else if (tick_i && rep_q >= RC_CAP) begin
            rep_q <= '0;
        end else if (replay_o) begin
            rep_q <= rep_q + 1'b1;
        end
    end
endmodule

// File: rtl/lirq_slice_timer.sv
// Catch-up slice timer: while a backlog is owed, signals a firing every
// period / (min(backlog, SLICE_MAX) + 1) cycles (at least every cycle).
// Assumes: block_i holds a due firing back until the path is free.
module lirq_slice_timer #(
    parameter int BL_W      = 8,
    parameter int PER_W     = 12,
    parameter int SLICE_MAX = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BL_W-1:0]  backlog_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             block_i,
    output logic             fire_o
);
    localparam int DIV_W = $clog2(SLICE_MAX + 2);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] slice;
    logic [PER_W-1:0] slice_eff;
    logic [PER_W:0]   cnt_inc;
    logic [DIV_W-1:0] divisor;
    logic             nz;
    logic             due;

    assign nz = backlog_i != '0;

    // Divisor grows with the backlog up to SLICE_MAX + 1.
    always_comb begin
        if (backlog_i > BL_W'(SLICE_MAX)) begin
            divisor = DIV_W'(SLICE_MAX + 1);
        end else begin
            divisor = DIV_W'(backlog_i) + 1'b1;
        end
    end

    // Slice length with a one-cycle floor, and due test.
    always_comb begin
        slice     = period_i / PER_W'(divisor);
        slice_eff = (slice == '0) ? PER_W'(1) : slice;
        cnt_inc   = {1'b0, cnt_q} + {{PER_W{1'b0}}, 1'b1};
        due       = cnt_inc >= {1'b0, slice_eff};
    end

    assign fire_o = nz && due && !block_i;

    // Slice counter: held at zero when idle, restarted on firing, parked when due.
    always_ff @(posedge clk) begin
        if (!rst_n || !nz) begin
            cnt_q <= '0;
        end else if (fire_o) begin
            cnt_q <= '0;
        end else if (!due) begin
            cnt_q <= cnt_inc[PER_W-1:0];
        end
    end
endmodule

// File: rtl/lost_irq_replay.sv
// Lost interrupt reinjection tracker: counts undelivered periodic interrupts
// and replays them on acknowledge or from a catch-up slice timer.
// Assumes: dlv_ok_i is valid in the cycle irq_req_o is high; one attempt per edge.
module lost_irq_replay
    import lirq_pkg::*;
#(
    parameter int BL_W      = 8,
    parameter int PER_W     = 12,
    parameter int ACK_CAP   = 20,
    parameter int SLICE_MAX = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ack_rd_i,
    input  logic             dlv_ok_i,
    input  logic [PER_W-1:0] period_i,
    output logic             irq_req_o,
    output logic             clr_sts_o,
    output logic [BL_W-1:0]  backlog_o
);
    localparam logic [BL_W-1:0] BL_MAX = '1;

    logic [BL_W-1:0]  backlog_q;
    logic [BL_W-1:0]  bl_scaled;
    logic [BL_W-1:0]  bl_next;
    logic [PER_W-1:0] period_q;
    att_kind_e        att_q;
    att_kind_e        att_d;
    logic             clr_q;
    logic             replay_go;
    logic             catch_go;
    logic             catch_block;
    logic             bl_nz;

    assign bl_nz = backlog_q != '0;

    lirq_rescale #(.BL_W(BL_W), .PER_W(PER_W)) u_rescale (
        .bl_i      (backlog_q),
        .old_per_i (period_q),
        .new_per_i (period_i),
        .bl_o      (bl_scaled)
    );

    lirq_ack_gate #(.CAP(ACK_CAP)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .ack_i    (ack_rd_i),
        .bl_nz_i  (bl_nz),
        .replay_o (replay_go)
    );

    assign catch_block = tick_i || replay_go || (att_q != ATT_NONE);

    lirq_slice_timer #(.BL_W(BL_W), .PER_W(PER_W), .SLICE_MAX(SLICE_MAX)) u_slice (
        .clk       (clk),
        .rst_n     (rst_n),
        .backlog_i (backlog_q),
        .period_i  (period_q),
        .block_i   (catch_block),
        .fire_o    (catch_go)
    );

    // Apply delivery feedback of the attempt in flight to the rescaled backlog.
    always_comb begin
        bl_next = bl_scaled;
        if (att_q == ATT_TICK && !dlv_ok_i) begin
            if (bl_scaled != BL_MAX) begin
                bl_next = bl_scaled + 1'b1;
            end
        end else if ((att_q == ATT_REPLAY || att_q == ATT_CATCH) && dlv_ok_i) begin
            if (bl_scaled != '0) begin
                bl_next = bl_scaled - 1'b1;
            end
        end
    end

    // Pick at most one new attempt: tick, then replay, then catch-up.
    always_comb begin
        if (tick_i) begin
            att_d = ATT_TICK;
        end else if (replay_go) begin
            att_d = ATT_REPLAY;
        end else if (catch_go) begin
            att_d = ATT_CATCH;
        end else begin
            att_d = ATT_NONE;
        end
    end

    // State registers: backlog, period, attempt kind, status clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            backlog_q <= '0;
            period_q  <= period_i;
            att_q     <= ATT_NONE;
            clr_q     <= 1'b0;
        end else begin
            backlog_q <= bl_next;
            period_q  <= period_i;
            att_q     <= att_d;
            clr_q     <= ack_rd_i && !replay_go;
        end
    end

    assign irq_req_o = att_q != ATT_NONE;
    assign clr_sts_o = clr_q;
    assign backlog_o = backlog_q;
endmodule

// File: rtl/lirq_checker.sv
// Property checker for lost_irq_replay, attached by bind.
module lirq_checker #(
    parameter int BL_W  = 8,
    parameter int PER_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             ack_rd_i,
    input logic [PER_W-1:0] period_i,
    input logic [PER_W-1:0] period_q,
    input logic             irq_req_o,
    input logic             clr_sts_o,
    input logic [BL_W-1:0]  backlog_o
);
    localparam logic [BL_W-1:0] BL_MAX = '1;

    AST_RST_STATE: assert property (@(posedge clk)
        !rst_n |=> (backlog_o == '0 && !irq_req_o && !clr_sts_o)); // R1

    AST_TICK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> irq_req_o); // R2

    AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (backlog_o == '0) |=> (backlog_o <= BL_W'(1))); // R3

    AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (backlog_o == BL_MAX && period_i == period_q) |=> (backlog_o >= BL_MAX - 1'b1)); // R3

    AST_CLR_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sts_o |-> $past(ack_rd_i)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (backlog_o == '0 && !tick_i && !irq_req_o) |=> !irq_req_o); // R9
endmodule

bind lost_irq_replay lirq_checker #(.BL_W(BL_W), .PER_W(PER_W)) u_lirq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .ack_rd_i  (ack_rd_i),
    .period_i  (period_i),
    .period_q  (period_q),
    .irq_req_o (irq_req_o),
    .clr_sts_o (clr_sts_o),
    .backlog_o (backlog_o)
);

// File: tb/sim_lost_irq_replay.sv
`timescale 1ns/1ps
module sim_lost_irq_replay;
    localparam int BL_W  = 8;
    localparam int PER_W = 12;
    localparam int MAXB  = 255;
    localparam int CAP   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             ack_rd_i = 1'b0;
    logic             dlv_ok_i = 1'b0;
    logic [PER_W-1:0] period_i = '0;
    logic             irq_req_o;
    logic             clr_sts_o;
    logic [BL_W-1:0]  backlog_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_b, m_rep, m_cnt, m_per, m_kind, m_clr;

    always #2.5 clk = ~clk;

    lost_irq_replay #(.BL_W(BL_W), .PER_W(PER_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ack_rd_i(ack_rd_i),
        .dlv_ok_i(dlv_ok_i), .period_i(period_i), .irq_req_o(irq_req_o),
        .clr_sts_o(clr_sts_o), .backlog_o(backlog_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One edge of the reference model, built from the requirements.
    task automatic step_model(bit tk, bit ak, bit dv, int per);
        int b, s, dvs;
        bit nz, rep_ok, due, fire;
        nz = (m_b != 0);
        b = m_b;
        if (per != m_per && per != 0) begin
            b = b * m_per / per;
            if (b > MAXB) b = MAXB;
        end
        if (m_kind == 1 && !dv) begin
            if (b < MAXB) b = b + 1;
        end else if ((m_kind == 2 || m_kind == 3) && dv && b > 0) begin
            b = b - 1;
        end
        rep_ok = ak && !tk && nz && (m_rep < CAP);
        dvs = ((m_b > 7) ? 7 : m_b) + 1;
        s = m_per / dvs;
        if (s < 1) s = 1;
        due = (m_cnt + 1) >= s;
        fire = nz && due && !tk && !rep_ok && (m_kind == 0);
        if (!nz || fire) m_cnt = 0;
        else if (!due) m_cnt = m_cnt + 1;
        if (tk && m_rep >= CAP) m_rep = 0;
        else if (rep_ok) m_rep = m_rep + 1;
        m_kind = tk ? 1 : rep_ok ? 2 : fire ? 3 : 0;
        m_clr = ak && !rep_ok;
        m_per = per;
        m_b = b;
    endtask

    // Drive one cycle at the falling edge, step the model, compare outputs.
    task automatic cyc(bit tk, bit ak, bit dv, int per);
        string itag;
        tick_i = tk; ack_rd_i = ak; dlv_ok_i = dv; period_i = PER_W'(per);
        @(posedge clk);
        step_model(tk, ak, dv, per);
        @(negedge clk);
        case (m_kind)
            1: itag = "R2 irq";
            2: itag = "R5 irq";
            3: itag = "R8 irq";
            default: itag = "R9 R10 irq";
        endcase
        check(itag, int'(irq_req_o), (m_kind != 0) ? 1 : 0);
        check("R3 R4 backlog", int'(backlog_o), m_b);
        check("R6 clr", int'(clr_sts_o), m_clr);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int irq_seen;
        int per_sel;
        void'($urandom(32'h5eed_1234));
        // reset, R1
        period_i = PER_W'(4000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_b = 0; m_rep = 0; m_cnt = 0; m_per = 4000; m_kind = 0; m_clr = 0;
        check("R1 backlog", int'(backlog_o), 0);
        check("R1 irq", int'(irq_req_o), 0);
        check("R1 clr", int'(clr_sts_o), 0);

        // undelivered ticks, R2
        cyc(1, 0, 0, 4000);
        check("R2 tick irq", int'(irq_req_o), 1);
        cyc(0, 0, 0, 4000);
        check("R2 backlog one", int'(backlog_o), 1);
        cyc(1, 0, 0, 4000);
        cyc(1, 0, 0, 4000);
        cyc(0, 0, 0, 4000);
        check("R2 backlog three", int'(backlog_o), 3);

        // rescale 3 * 4000 / 2000 = 6, R4
        cyc(0, 0, 0, 2000);
        check("R4 rescale", int'(backlog_o), 6);

        // acknowledge replay delivered, R5
        cyc(0, 1, 0, 2000);
        check("R5 replay irq", int'(irq_req_o), 1);
        check("R5 no clear", int'(clr_sts_o), 0);
        cyc(0, 0, 1, 2000);
        check("R5 decrement", int'(backlog_o), 5);

        // replay cap reached, R6
        for (int i = 0; i < CAP - 1; i++) begin
            cyc(0, 1, 0, 2000);
            cyc(0, 0, 0, 2000);
        end
        cyc(0, 1, 0, 2000);
        check("R6 cap clear", int'(clr_sts_o), 1);
        check("R6 cap no irq", int'(irq_req_o), 0);

        // tick resets replay count, R7
        cyc(1, 0, 0, 2000);
        cyc(0, 0, 1, 2000);
        cyc(0, 1, 0, 2000);
        check("R7 replay again", int'(irq_req_o), 1);
        cyc(0, 0, 0, 2000);

        // tick beats acknowledge replay, R10
        cyc(1, 1, 0, 2000);
        check("R10 tick irq", int'(irq_req_o), 1);
        check("R10 ack clears", int'(clr_sts_o), 1);
        cyc(0, 0, 1, 2000);
        check("R10 backlog kept", int'(backlog_o), 5);

        // rescale 5 * 2000 / 64 = 156 then catch-up drain, R8
        cyc(0, 0, 0, 64);
        check("R4 rescale down", int'(backlog_o), 156);
        for (int i = 0; i < 4000 && backlog_o != 0; i++) cyc(0, 0, 1, 64);
        check("R8 drained", int'(backlog_o), 0);
        irq_seen = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(0, 0, 1, 64);
            if (irq_req_o) irq_seen++;
        end
        check("R9 idle quiet", irq_seen, 0);

        // saturation and floor, R3
        cyc(0, 0, 0, 16);
        for (int i = 0; i < 300; i++) cyc(1, 0, 0, 16);
        cyc(0, 0, 0, 16);
        check("R3 saturate", int'(backlog_o), MAXB);
        for (int i = 0; i < 3000 && backlog_o != 0; i++) cyc(0, 0, 1, 16);
        check("R3 floor", int'(backlog_o), 0);

        // constrained random traffic against the model
        per_sel = 100;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 200 == 0) begin
                case ($urandom % 6)
                    0: per_sel = 16;
                    1: per_sel = 40;
                    2: per_sel = 100;
                    3: per_sel = 500;
                    4: per_sel = 1000;
                    default: per_sel = 0;
                endcase
            end
            cyc(($urandom % 8) == 0, ($urandom % 6) == 0, ($urandom % 2) == 1, per_sel);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule